// File: doc/BRIEF.md
# Bitwise Logic Execute Unit

This unit carries out the three bitwise instructions of an 8-bit processor core: AND, OR and XOR. A sequencer pulses `start` with an operation code, an operand-source code, a destination register index and either a source register index or an immediate byte. The unit combines the destination register with the second operand, writes the result back into the destination, refreshes a four-bit flag set and steps the program counter. It answers with a one-cycle `done`.

The second operand can come from three places. It can be another 8-bit register, or the instruction's immediate byte. It can also be a memory byte whose 16-bit address is held in an even/odd register pair. A memory operand is fetched with a request/valid handshake, and the unit waits in a dedicated state until the byte arrives. The eight-entry register file is internal. It has a preload write port and a read-observation port, so the surrounding logic or a bench can load it and inspect it.

Top module: `logic_exec_unit`

## Requirements
- R1: The result of the operation is written into register `dst_idx`: AND for `op_sel`=0, OR for `op_sel`=1 and XOR for `op_sel`=2. The destination value and the second operand are combined bit by bit. The immediate form with AND performs a true AND with the immediate byte.
- R2: The zero flag, `flags[3]`, is 1 exactly when the 8-bit result is 0x00, and 0 otherwise.
- R3: After each of the three operations, the subtract flag (`flags[2]`) and the carry flag (`flags[0]`) are 0.
- R4: The half-carry flag, `flags[1]`, is 1 after AND and 0 after OR or XOR.
- R5: With `src_sel`=1 (memory), `bus_req` rises in the cycle after `start` is accepted and stays high until `bus_valid` is sampled. `bus_addr` equals {reg[src_idx with bit 0 cleared], reg[src_idx with bit 0 set]}, with the even register as the high byte. The operand is the `bus_rdata` byte sampled when `bus_valid` is high.
- R6: The register form (`src_sel`=0) and the memory form advance `pc` by 1. The immediate form (`src_sel`=2) advances it by 2.
- R7: After reset, `pc` is 0x0100, flags are 0000, every register is 0x00, and both `done` and `bus_req` are 0.
- R8: For the register, immediate and no-op forms, `done` is high for one cycle in the cycle after `start`. For the memory form, it is high in the cycle after `bus_valid` is sampled. The register, the flags and `pc` take their new values in that same cycle and do not change earlier.
- R9: When `src_sel`=3 or `op_sel`=3, the instruction is a no-op: `done` still pulses, and registers, flags and `pc` stay unchanged.
- R10: A `start` that arrives while a memory operand is awaited is ignored. It causes no extra `done` and no change of state.
- R11: A preload write (`pre_we`) stores `pre_data` into register `pre_idx`. If it targets the register that a result is written to in the same cycle, the result wins. A preload to a different register in that cycle also takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| op_sel | input | 2 | 0 AND, 1 OR, 2 XOR, 3 no-op |
| src_sel | input | 2 | 0 register, 1 memory via pair, 2 immediate, 3 no-op |
| dst_idx | input | 3 | Destination register index |
| src_idx | input | 3 | Source register, or any register of the address pair |
| imm_byte | input | 8 | Immediate operand |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Memory read request |
| bus_addr | output | 16 | Memory read address |
| bus_valid | input | 1 | Read data valid |
| bus_rdata | input | 8 | Read data |
| pre_we | input | 1 | Register preload strobe |
| pre_idx | input | 3 | Preload register index |
| pre_data | input | 8 | Preload value |
| obs_idx | input | 3 | Register index to observe |
| obs_data | output | 8 | Content of register `obs_idx` |
| flags | output | 4 | {zero, subtract, half-carry, carry} |
| pc | output | 16 | Program counter |

## Verification
The two functions that can meet in one cycle are result writeback and preload. The bench drives `pre_we` on the very edge where an instruction commits. In one case the preload targets the destination register, and the bench expects the computed result, not the preload value. In the other case it targets a different register, and the bench expects both writes to land. A second overlap is a fresh `start` arriving while a memory byte is awaited. The bench asserts one during the wait and judges, cycle by cycle against its model, that no extra `done`, flag change or `pc` step appears.

// File: rtl/logop_pkg.sv
package logop_pkg;

   typedef enum logic [1:0] {
      OP_AND  = 2'd0,
      OP_OR   = 2'd1,
      OP_XOR  = 2'd2,
      OP_NONE = 2'd3
   } lop_op_e;

   typedef enum logic [1:0] {
      SRC_REG  = 2'd0,
      SRC_MEM  = 2'd1,
      SRC_IMM  = 2'd2,
      SRC_NONE = 2'd3
   } lop_src_e;

   typedef struct packed {
      logic zf;
      logic nf;
      logic hf;
      logic cf;
   } lop_flags_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } lop_state_e;

endpackage

// File: rtl/logop_regfile.sv
module logop_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 8,
   parameter int NRD    = 5,
   localparam int RAW   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_en,
   input  logic [RAW-1:0]    wb_idx,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              pl_en,
   input  logic [RAW-1:0]    pl_idx,
   input  logic [DATA_W-1:0] pl_data,
   input  logic [RAW-1:0]    rd_idx  [NRD],
   output logic [DATA_W-1:0] rd_data [NRD]
);

   logic [DATA_W-1:0] regs_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_entry
      logic hit_wb;
      logic hit_pl;
      assign hit_wb = wb_en && (wb_idx == RAW'(g));
      assign hit_pl = pl_en && (pl_idx == RAW'(g));
      always_ff @(posedge clk) begin
         if (!rst_n)      regs_q[g] <= '0;
         else if (hit_wb) regs_q[g] <= wb_data;
         else if (hit_pl) regs_q[g] <= pl_data;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = regs_q[rd_idx[p]];
   end

   // R11
   wb_over_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && pl_en && (wb_idx == pl_idx)) |=> (regs_q[$past(wb_idx)] == $past(wb_data)));

endmodule

// File: rtl/logop_alu.sv
module logop_alu
   import logop_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  lop_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output lop_flags_t        fl
);

   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = '0;
      endcase
   end

   always_comb begin
      fl.zf = (res == '0);
      fl.nf = 1'b0;
      fl.hf = (op == OP_AND);
      fl.cf = 1'b0;
   end

endmodule

// File: rtl/logop_ctrl.sv
module logop_ctrl
   import logop_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          NREG     = 8,
   parameter int          PC_W     = 16,
   parameter logic [15:0] PC_RESET = 16'h0100,
   localparam int         RAW      = $clog2(NREG),
   localparam int         ADDR_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_sel,
   input  logic [1:0]        src_sel,
   input  logic [RAW-1:0]    dst_idx,
   input  logic [DATA_W-1:0] imm_byte,
   input  logic [DATA_W-1:0] src_rd,
   input  logic [DATA_W-1:0] pair_hi,
   input  logic [DATA_W-1:0] pair_lo,
   input  logic              bus_valid,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] alu_res,
   input  lop_flags_t        alu_fl,
   output logic [RAW-1:0]    rd_dst_idx,
   output lop_op_e           alu_op,
   output logic [DATA_W-1:0] alu_b,
   output logic              wb_en,
   output logic [RAW-1:0]    wb_idx,
   output logic [DATA_W-1:0] wb_data,
   output logic              done,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output lop_flags_t        flags,
   output logic [PC_W-1:0]   pc
);

   lop_state_e        state_q;
   lop_op_e           op_l;
   logic [RAW-1:0]    dst_l;
   logic [ADDR_W-1:0] addr_l;
   logic              done_q;
   lop_flags_t        flags_q;
   logic [PC_W-1:0]   pc_q;

   logic accept, legal, go_wait, commit;
   logic [PC_W-1:0] step;

   assign accept  = start && (state_q == ST_IDLE);
   assign legal   = (op_sel != OP_NONE) && (src_sel != SRC_NONE);
   assign go_wait = accept && legal && (src_sel == SRC_MEM);

   always_comb begin
      if (state_q == ST_WAIT) begin
         alu_op     = op_l;
         rd_dst_idx = dst_l;
         alu_b      = bus_rdata;
         commit     = bus_valid;
         step       = PC_W'(1);
      end else begin
         alu_op     = lop_op_e'(op_sel);
         rd_dst_idx = dst_idx;
         alu_b      = (src_sel == SRC_IMM) ? imm_byte : src_rd;
         commit     = accept && legal && (src_sel != SRC_MEM);
         step       = (src_sel == SRC_IMM) ? PC_W'(2) : PC_W'(1);
      end
   end

   assign wb_en   = commit;
   assign wb_idx  = rd_dst_idx;
   assign wb_data = alu_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_l    <= OP_AND;
         dst_l   <= '0;
         addr_l  <= '0;
         done_q  <= 1'b0;
         flags_q <= '0;
         pc_q    <= PC_W'(PC_RESET);
      end else begin
         done_q <= (accept && !go_wait) || ((state_q == ST_WAIT) && bus_valid);
         if (go_wait) begin
            state_q <= ST_WAIT;
            op_l    <= lop_op_e'(op_sel);
            dst_l   <= dst_idx;
            addr_l  <= {pair_hi, pair_lo};
         end else if ((state_q == ST_WAIT) && bus_valid) begin
            state_q <= ST_IDLE;
         end
         if (commit) begin
            flags_q <= alu_fl;
            pc_q    <= pc_q + step;
         end
      end
   end

   assign done     = done_q;
   assign bus_req  = (state_q == ST_WAIT);
   assign bus_addr = addr_l;
   assign flags    = flags_q;
   assign pc       = pc_q;

   // R3
   nc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!flags_q.nf && !flags_q.cf));

   // R4
   hc_by_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (flags_q.hf == ($past(alu_op) == OP_AND)));

   // R2
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (flags_q.zf == ($past(wb_data) == '0)));

   // R6
   pc_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && legal && (src_sel == SRC_IMM)) |=> (pc_q == $past(pc_q) + PC_W'(2)));

   // R6
   pc_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_WAIT) && bus_valid) |=> (pc_q == $past(pc_q) + PC_W'(1)));

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_valid) |=> (bus_req && $stable(bus_addr)));

   // R10
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_valid) |=> (!done_q && $stable(pc_q) && $stable(flags_q)));

   // R9
   noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !legal) |=> (done_q && $stable(pc_q) && $stable(flags_q)));

endmodule

// File: rtl/logic_exec_unit.sv
module logic_exec_unit
   import logop_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          NREG     = 8,
   parameter int          PC_W     = 16,
   parameter logic [15:0] PC_RESET = 16'h0100,
   localparam int         RAW      = $clog2(NREG),
   localparam int         ADDR_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_sel,
   input  logic [1:0]        src_sel,
   input  logic [RAW-1:0]    dst_idx,
   input  logic [RAW-1:0]    src_idx,
   input  logic [DATA_W-1:0] imm_byte,
   output logic              done,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_valid,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              pre_we,
   input  logic [RAW-1:0]    pre_idx,
   input  logic [DATA_W-1:0] pre_data,
   input  logic [RAW-1:0]    obs_idx,
   output logic [DATA_W-1:0] obs_data,
   output logic [3:0]        flags,
   output logic [PC_W-1:0]   pc
);

   localparam int NRD    = 5;
   localparam int RP_DST = 0;
   localparam int RP_SRC = 1;
   localparam int RP_HI  = 2;
   localparam int RP_LO  = 3;
   localparam int RP_OBS = 4;

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("PC_W must be at least 2");
   end

   logic [RAW-1:0]    rd_idx  [NRD];
   logic [DATA_W-1:0] rd_data [NRD];
   logic [RAW-1:0]    rd_dst_idx;
   lop_op_e           alu_op;
   logic [DATA_W-1:0] alu_b, alu_res, wb_data;
   lop_flags_t        alu_fl, flags_s;
   logic              wb_en;
   logic [RAW-1:0]    wb_idx;

   assign rd_idx[RP_DST] = rd_dst_idx;
   assign rd_idx[RP_SRC] = src_idx;
   assign rd_idx[RP_HI]  = {src_idx[RAW-1:1], 1'b0};
   assign rd_idx[RP_LO]  = {src_idx[RAW-1:1], 1'b1};
   assign rd_idx[RP_OBS] = obs_idx;

   logop_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wb_en   (wb_en),
      .wb_idx  (wb_idx),
      .wb_data (wb_data),
      .pl_en   (pre_we),
      .pl_idx  (pre_idx),
      .pl_data (pre_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   logop_alu #(.DATA_W(DATA_W)) u_alu (
      .op  (alu_op),
      .a   (rd_data[RP_DST]),
      .b   (alu_b),
      .res (alu_res),
      .fl  (alu_fl)
   );

   logop_ctrl #(.DATA_W(DATA_W), .NREG(NREG), .PC_W(PC_W), .PC_RESET(PC_RESET)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_sel     (op_sel),
      .src_sel    (src_sel),
      .dst_idx    (dst_idx),
      .imm_byte   (imm_byte),
      .src_rd     (rd_data[RP_SRC]),
      .pair_hi    (rd_data[RP_HI]),
      .pair_lo    (rd_data[RP_LO]),
      .bus_valid  (bus_valid),
      .bus_rdata  (bus_rdata),
      .alu_res    (alu_res),
      .alu_fl     (alu_fl),
      .rd_dst_idx (rd_dst_idx),
      .alu_op     (alu_op),
      .alu_b      (alu_b),
      .wb_en      (wb_en),
      .wb_idx     (wb_idx),
      .wb_data    (wb_data),
      .done       (done),
      .bus_req    (bus_req),
      .bus_addr   (bus_addr),
      .flags      (flags_s),
      .pc         (pc)
   );

   assign obs_data = rd_data[RP_OBS];
   assign flags    = flags_s;

   // R8
   done_gates_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(pc) || $past(!rst_n)));

endmodule

// File: tb/logic_exec_unit_tb.sv
module logic_exec_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_sel = '0, src_sel = '0;
   logic [2:0]  dst_idx = '0, src_idx = '0;
   logic [7:0]  imm_byte = '0;
   logic        done, bus_req;
   logic [15:0] bus_addr;
   logic        bus_valid = 1'b0;
   logic [7:0]  bus_rdata = '0;
   logic        pre_we = 1'b0;
   logic [2:0]  pre_idx = '0;
   logic [7:0]  pre_data = '0;
   logic [2:0]  obs_idx = '0;
   logic [7:0]  obs_data;
   logic [3:0]  flags;
   logic [15:0] pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   logic_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .src_sel(src_sel),
      .dst_idx(dst_idx), .src_idx(src_idx), .imm_byte(imm_byte), .done(done),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_valid(bus_valid), .bus_rdata(bus_rdata),
      .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data), .obs_idx(obs_idx),
      .obs_data(obs_data), .flags(flags), .pc(pc)
   );

   // behavioural reference state
   int   m_reg [8];
   int   m_pc = 'h100;
   int   m_flags = 0;
   logic m_done = 1'b0;
   logic m_req = 1'b0;
   logic cmp_en = 1'b0;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) m_done <= 1'b0;

   always @(negedge clk) begin
      if (cmp_en) begin
         check("R6", "pc", int'(pc), m_pc);
         check("R2 R3 R4", "flags", int'(flags), m_flags);
         check("R8", "done", int'(done), int'(m_done));
         check("R5", "bus_req", int'(bus_req), int'(m_req));
      end
   end

   function automatic int model_op(input int op, input int a, input int b);
      case (op)
         0: return a & b;
         1: return a | b;
         default: return a ^ b;
      endcase
   endfunction

   task automatic model_commit(input int op, input int dst, input int b, input int stp);
      int r;
      r = model_op(op, m_reg[dst], b) & 'hff;
      m_reg[dst] = r;
      m_flags = ((r == 0) ? 8 : 0) | ((op == 0) ? 2 : 0);
      m_pc = (m_pc + stp) & 'hffff;
   endtask

   task automatic preload(input int idx, input int val);
      @(negedge clk);
      pre_we = 1'b1; pre_idx = 3'(idx); pre_data = 8'(val);
      @(posedge clk); #1;
      m_reg[idx] = val;
      @(negedge clk);
      pre_we = 1'b0;
   endtask

   task automatic check_reg(input string req, input int idx);
      @(negedge clk);
      obs_idx = 3'(idx);
      #1;
      check(req, $sformatf("reg%0d", idx), int'(obs_data), m_reg[idx]);
   endtask

   // one instruction; optional preload on the accept edge, optional start poke during wait
   task automatic run_op(input int op, input int src, input int dst, input int sidx,
                         input int imm, input int lat, input int mbyte,
                         input bit pl, input int pl_i, input int pl_v, input bit poke);
      int eaddr;
      @(negedge clk);
      start = 1'b1; op_sel = 2'(op); src_sel = 2'(src);
      dst_idx = 3'(dst); src_idx = 3'(sidx); imm_byte = 8'(imm);
      pre_we = pl; pre_idx = 3'(pl_i); pre_data = 8'(pl_v);
      eaddr = (m_reg[sidx & 6] << 8) | m_reg[sidx | 1];
      if (src == 1 && op != 3) begin
         @(posedge clk); #1;
         m_req = 1'b1;
         if (pl) m_reg[pl_i] = pl_v;
         @(negedge clk);
         start = 1'b0; pre_we = 1'b0;
         // R5 address from even/odd pair
         check("R5", "bus_addr", int'(bus_addr), eaddr);
         for (int i = 0; i < lat; i++) begin
            start = poke; op_sel = 2'd1; src_sel = 2'd2; dst_idx = 3'(dst); imm_byte = 8'hff;
            @(negedge clk);
         end
         start = 1'b0;
         bus_valid = 1'b1; bus_rdata = 8'(mbyte);
         @(posedge clk); #1;
         m_req = 1'b0;
         model_commit(op, dst, mbyte, 1);
         m_done = 1'b1;
         @(negedge clk);
         bus_valid = 1'b0;
      end else begin
         @(posedge clk); #1;
         if (op != 3 && src != 3)
            model_commit(op, dst, (src == 2) ? imm : m_reg[sidx], (src == 2) ? 2 : 1);
         if (pl && !(op != 3 && src != 3 && pl_i == dst)) m_reg[pl_i] = pl_v;
         m_done = 1'b1;
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      start = 1'b0; pre_we = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7", "pc", int'(pc), 'h100);
      check("R7", "flags", int'(flags), 0);
      check("R7", "done", int'(done), 0);
      check("R7", "bus_req", int'(bus_req), 0);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      for (int i = 0; i < 8; i++) check_reg("R7", i);

      preload(2, 'hF1);
      preload(3, 'h1F);
      preload(4, 'hC0);
      preload(5, 'h00);
      preload(7, 'h3C);

      // R1 R4 register AND
      run_op(0, 0, 2, 3, 0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R1", 2);
      // R1 OR and XOR register forms
      preload(2, 'hF1);
      run_op(1, 0, 2, 3, 0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R1", 2);
      preload(2, 'hF1);
      run_op(2, 0, 2, 3, 0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R1", 2);
      // R2 zero result via XOR with itself
      run_op(2, 0, 7, 7, 0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R2", 7);
      // R1 R6 immediate AND is a true AND
      run_op(0, 2, 3, 0, 'hF0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R1", 3);
      run_op(1, 2, 6, 0, 'h00, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R2", 6);
      // R5 memory XOR with latency 2
      preload(3, 'h1F);
      run_op(2, 1, 3, 5, 0, 2, 'hF1, 0, 0, 0, 0);
      idle(1);
      check_reg("R5", 3);
      // R5 memory AND with data valid immediately, zero result
      run_op(0, 1, 3, 4, 0, 0, 'h00, 0, 0, 0, 0);
      idle(1);
      check_reg("R5", 3);
      // R10 start pokes during wait are ignored
      preload(2, 'h0F);
      run_op(1, 1, 2, 4, 0, 3, 'hA0, 0, 0, 0, 1);
      idle(2);
      check_reg("R10", 2);
      // R9 no-op forms
      run_op(0, 3, 2, 3, 0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R9", 2);
      run_op(3, 2, 2, 0, 'h00, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R9", 2);
      // R8 back-to-back instructions
      preload(1, 'h81);
      run_op(0, 2, 1, 0, 'h01, 0, 0, 0, 0, 0, 0);
      run_op(1, 2, 1, 0, 'h80, 0, 0, 0, 0, 0, 0);
      run_op(2, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0);
      idle(1);
      check_reg("R8", 1);
      // R11 preload collides with writeback on the destination
      preload(6, 'hF0);
      run_op(1, 2, 6, 0, 'h0F, 0, 0, 1, 6, 'h55, 0);
      idle(1);
      check_reg("R11", 6);
      // R11 preload to another register in the commit cycle
      run_op(2, 2, 6, 0, 'hFF, 0, 0, 1, 0, 'h77, 0);
      idle(1);
      check_reg("R11", 6);
      check_reg("R11", 0);
      idle(2);
      finish_run();
   end

endmodule